// File: doc/BRIEF.md
# Multi-output monotone response checker

This block judges the output stream of a circuit with k outputs during test. Each valid response word is read as an unsigned value between 0 and q-1, where q = 2^k. Adjacent words are compared by magnitude, and three counters record how often the value rose, how often it fell and how often it changed at all. A fourth counter records how many words carried a value that a q-bit exclusion mask declares impossible.

A run begins with a start pulse. The pulse clears the counters and latches the run configuration: the number of distinct values the good circuit produces, the exclusion mask and the selector that picks which pair of counters is compared with the reference. The reference value is the expected distinct count minus one. Words are then presented with a valid strobe. The last word carries an end marker. One cycle later `done` rises and `pass` shows the verdict. A good response climbs through its values in strictly ascending blocks, so the whole check needs counters only slightly wider than k bits, however long the test is.

Top module: `mono_resp_check`

## Requirements
- R1: After reset, and in the cycle after a start pulse, all four counts read 0. After reset `done` and `pass` are 0.
- R2: In a run, each valid word after the first is compared with the previous valid word. A greater value adds one to the ascent count, a smaller value adds one to the descent count, and any difference adds one to the change count. The new counts are visible in the cycle after the word.
- R3: The first valid word of a run only records the previous value and adds to no step count. It can still be counted as forbidden.
- R4: Each valid word with value v adds one to the forbidden count when bit v of the mask latched at start is 1 (bit i stands for value i).
- R5: Every counter saturates at 2q-1, which is all ones in k+1 bits.
- R6: When the end marker is seen during a run, the word presented in the same cycle is still counted. `done` is 1 from the next cycle until the next start pulse and is 0 while a run is active.
- R7: `pass` is 1 only while `done` is 1, the forbidden count is 0 and the counters picked by the selector match. Let ref = expected distinct count - 1. The selector values are: 0 means ascents = ref and descents = 0; 1 means ascents = ref and changes = ref; 2 means descents = 0 and changes = ref; 3 means all three conditions hold.
- R8: Outside a run (idle or done), valid words and end markers leave all counts and `done` unchanged.
- R9: While no counter is saturated, the change count equals the ascent count plus the descent count.
- R10: A start pulse during a run restarts it. The previous value is forgotten and the counters clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins a run, clears counters, latches configuration |
| wordValid | input | 1 | Qualifies `wordIn` |
| wordIn | input | OUT_BITS | Response word from the circuit under test |
| seqEnd | input | 1 | Marks the last word of the run |
| expDistinct | input | OUT_BITS+1 | Number of distinct values in a good response (1..q) |
| forbidMask | input | 2^OUT_BITS | Bit i set means value i must never appear |
| pairSel | input | 2 | Chooses which counters form the verdict |
| ascCount | output | OUT_BITS+1 | Ascending steps |
| descCount | output | OUT_BITS+1 | Descending steps |
| chgCount | output | OUT_BITS+1 | Value changes |
| forbidCount | output | OUT_BITS+1 | Words with a forbidden value |
| done | output | 1 | Run complete |
| pass | output | 1 | Verdict, valid while `done` is 1 |

## Verification
The assertions check the following on every cycle:
- Counters clear after a start pulse.
- A saturated counter stays at its maximum.
- The change count stays equal to the ascent count plus the descent count until a counter saturates.
- The first word of a run leaves the step counts alone.
- `done` follows the end marker.
- Counts freeze once the run is done.
- `pass` never rises without `done`.

Only the bench scenarios can show that the verdict is right. They cover each selector encoding against good and faulty sequences, sequences that use only some of the values, forbidden values hit by the first word, restart in the middle of a run, and saturation under a long alternating sequence.

// File: rtl/mrc_pkg.sv
package mrc_pkg;

  typedef struct packed {
    logic clearAll;
    logic takeWord;
    logic finish;
  } ctrlStrobe_t;

  typedef enum logic [1:0] {
    PAIR_ASC_DESC = 2'd0,
    PAIR_ASC_CHG  = 2'd1,
    PAIR_DESC_CHG = 2'd2,
    PAIR_ALL      = 2'd3
  } pairSel_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } runState_e;

  localparam int NUM_COUNTERS = 4;
  localparam int IDX_ASC  = 0;
  localparam int IDX_DESC = 1;
  localparam int IDX_CHG  = 2;
  localparam int IDX_FORB = 3;

endpackage

// File: rtl/mrc_sat_counter.sv
module mrc_sat_counter #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clear,
  input  logic             inc,
  output logic [WIDTH-1:0] count
);
  localparam logic [WIDTH-1:0] MAX_VAL = '1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      count <= '0;
    else if (clear)
      count <= '0;
    else if (inc && (count != MAX_VAL))
      count <= count + 1'b1;
  end

  // R5: a full counter does not wrap
  p_sat_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (count == MAX_VAL && !clear) |=> (count == MAX_VAL));

  // R1: clear yields zero
  p_clear_zero_r1: assert property (@(posedge clk) disable iff (!rstN)
    clear |=> (count == '0));

endmodule

// File: rtl/mrc_ctrl.sv
module mrc_ctrl
  import mrc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        wordValid,
  input  logic        seqEnd,
  output ctrlStrobe_t strobe,
  output logic        doneOut
);
  runState_e state;

  always_comb begin
    strobe = '0;
    if (start) begin
      strobe.clearAll = 1'b1;
    end else if (state == ST_RUN) begin
      strobe.takeWord = wordValid;
      strobe.finish   = seqEnd;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      state <= ST_IDLE;
    else if (start)
      state <= ST_RUN;
    else if (strobe.finish)
      state <= ST_DONE;
  end

  assign doneOut = (state == ST_DONE);

  // R6: end marker during a run raises done next cycle
  p_done_follows_end_r6: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && seqEnd && !start) |=> doneOut);

  // R6: start always drops done
  p_start_drops_done_r6: assert property (@(posedge clk) disable iff (!rstN)
    start |=> !doneOut);

endmodule

// File: rtl/mrc_datapath.sv
module mrc_datapath
  import mrc_pkg::*;
#(
  parameter int OUT_BITS = 3,
  parameter int CNT_W    = OUT_BITS + 1
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  ctrlStrobe_t                strobe,
  input  logic [OUT_BITS-1:0]        wordIn,
  input  logic [OUT_BITS:0]          expDistinct,
  input  logic [(2**OUT_BITS)-1:0]   forbidMask,
  input  logic [1:0]                 pairSel,
  output logic [CNT_W-1:0]           ascCount,
  output logic [CNT_W-1:0]           descCount,
  output logic [CNT_W-1:0]           chgCount,
  output logic [CNT_W-1:0]           forbidCount,
  output logic                       verdictOk
);
  localparam int Q = 2 ** OUT_BITS;
  localparam logic [CNT_W-1:0] MAX_VAL = '1;

  logic [OUT_BITS-1:0] prevWord;
  logic                havePrev;
  logic [OUT_BITS:0]   expReg;
  logic [Q-1:0]        maskReg;
  pairSel_e            selReg;

  logic stepUp, stepDown, stepChg, forbidHit;
  logic [NUM_COUNTERS-1:0] incVec;
  logic [CNT_W-1:0] cntArr [NUM_COUNTERS];

  // configuration latched at start
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      expReg  <= '0;
      maskReg <= '0;
      selReg  <= PAIR_ASC_DESC;
    end else if (strobe.clearAll) begin
      expReg  <= expDistinct;
      maskReg <= forbidMask;
      selReg  <= pairSel_e'(pairSel);
    end
  end

  // previous-value tracking
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevWord <= '0;
      havePrev <= 1'b0;
    end else if (strobe.clearAll) begin
      havePrev <= 1'b0;
    end else if (strobe.takeWord) begin
      prevWord <= wordIn;
      havePrev <= 1'b1;
    end
  end

  always_comb begin
    stepUp    = havePrev && (wordIn > prevWord);
    stepDown  = havePrev && (wordIn < prevWord);
    stepChg   = havePrev && (wordIn != prevWord);
    forbidHit = maskReg[wordIn];
    incVec           = '0;
    incVec[IDX_ASC]  = strobe.takeWord && stepUp;
    incVec[IDX_DESC] = strobe.takeWord && stepDown;
    incVec[IDX_CHG]  = strobe.takeWord && stepChg;
    incVec[IDX_FORB] = strobe.takeWord && forbidHit;
  end

  for (genvar g = 0; g < NUM_COUNTERS; g++) begin : g_cnt
    mrc_sat_counter #(.WIDTH(CNT_W)) u_cnt (
      .clk   (clk),
      .rstN  (rstN),
      .clear (strobe.clearAll),
      .inc   (incVec[g]),
      .count (cntArr[g])
    );
  end

  assign ascCount    = cntArr[IDX_ASC];
  assign descCount   = cntArr[IDX_DESC];
  assign chgCount    = cntArr[IDX_CHG];
  assign forbidCount = cntArr[IDX_FORB];

  // verdict against reference = distinct values - 1
  logic [CNT_W-1:0] refVal;
  logic ascOk, descOk, chgOk, pairOk;

  always_comb begin
    refVal = CNT_W'(expReg) - CNT_W'(1);
    ascOk  = (ascCount == refVal);
    descOk = (descCount == '0);
    chgOk  = (chgCount == refVal);
    case (selReg)
      PAIR_ASC_DESC: pairOk = ascOk && descOk;
      PAIR_ASC_CHG:  pairOk = ascOk && chgOk;
      PAIR_DESC_CHG: pairOk = descOk && chgOk;
      default:       pairOk = ascOk && descOk && chgOk;
    endcase
    verdictOk = pairOk && (forbidCount == '0);
  end

  // R9: changes split into ascents and descents until saturation
  p_chg_is_sum_r9: assert property (@(posedge clk) disable iff (!rstN)
    (ascCount != MAX_VAL && descCount != MAX_VAL && chgCount != MAX_VAL) |->
      ({1'b0, chgCount} == ({1'b0, ascCount} + {1'b0, descCount})));

  // R3: first word of a run produces no step
  p_first_no_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.takeWord && !havePrev) |=>
      ($stable(ascCount) && $stable(descCount) && $stable(chgCount)));

endmodule

// File: rtl/mono_resp_check.sv
module mono_resp_check
  import mrc_pkg::*;
#(
  parameter int OUT_BITS = 3
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      start,
  input  logic                      wordValid,
  input  logic [OUT_BITS-1:0]       wordIn,
  input  logic                      seqEnd,
  input  logic [OUT_BITS:0]         expDistinct,
  input  logic [(2**OUT_BITS)-1:0]  forbidMask,
  input  logic [1:0]                pairSel,
  output logic [OUT_BITS:0]         ascCount,
  output logic [OUT_BITS:0]         descCount,
  output logic [OUT_BITS:0]         chgCount,
  output logic [OUT_BITS:0]         forbidCount,
  output logic                      done,
  output logic                      pass
);
  localparam int CNT_W = OUT_BITS + 1;

  ctrlStrobe_t strobe;
  logic        verdictOk;

  mrc_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .wordValid (wordValid),
    .seqEnd    (seqEnd),
    .strobe    (strobe),
    .doneOut   (done)
  );

  mrc_datapath #(.OUT_BITS(OUT_BITS), .CNT_W(CNT_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .wordIn      (wordIn),
    .expDistinct (expDistinct),
    .forbidMask  (forbidMask),
    .pairSel     (pairSel),
    .ascCount    (ascCount),
    .descCount   (descCount),
    .chgCount    (chgCount),
    .forbidCount (forbidCount),
    .verdictOk   (verdictOk)
  );

  assign pass = done && verdictOk;

  // R7: no verdict without completion
  p_pass_needs_done_r7: assert property (@(posedge clk) disable iff (!rstN)
    pass |-> done);

  // R8: once done, input words leave counts untouched
  p_frozen_after_done_r8: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> ($stable(ascCount) && $stable(descCount) &&
                          $stable(chgCount) && $stable(forbidCount) && done));

endmodule

// File: tb/mono_resp_check_test.sv
module mono_resp_check_test;

  typedef struct packed {
    logic [23:0] seq;
    logic [3:0]  len;
    logic [7:0]  mask;
    logic [3:0]  expD;
    logic [1:0]  sel;
    logic [3:0]  eAsc;
    logic [3:0]  eDesc;
    logic [3:0]  eChg;
    logic [3:0]  eForb;
    logic        ePass;
  } vec_t;

  // seq holds words in octal, first word is the leftmost digit
  localparam vec_t VEC [8] = '{
    '{24'o01234567, 4'd8, 8'h00, 4'd8, 2'd0, 4'd7, 4'd0, 4'd7, 4'd0, 1'b1},
    '{24'o00133567, 4'd8, 8'h14, 4'd6, 2'd1, 4'd5, 4'd0, 4'd5, 4'd0, 1'b1},
    '{24'o01213457, 4'd8, 8'h00, 4'd8, 2'd0, 4'd6, 4'd1, 4'd7, 4'd0, 1'b0},
    '{24'o01245677, 4'd8, 8'h00, 4'd8, 2'd2, 4'd6, 4'd0, 4'd6, 4'd0, 1'b0},
    '{24'o22444666, 4'd8, 8'hAB, 4'd3, 2'd3, 4'd2, 4'd0, 4'd2, 4'd0, 1'b1},
    '{24'o22344666, 4'd8, 8'hAB, 4'd3, 2'd3, 4'd3, 4'd0, 4'd3, 4'd1, 1'b0},
    '{24'o55500000, 4'd3, 8'h00, 4'd1, 2'd1, 4'd0, 4'd0, 4'd0, 4'd0, 1'b1},
    '{24'o76543210, 4'd8, 8'h00, 4'd8, 2'd0, 4'd0, 4'd7, 4'd7, 4'd0, 1'b0}
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       start = 1'b0;
  logic       wordValid = 1'b0;
  logic [2:0] wordIn = '0;
  logic       seqEnd = 1'b0;
  logic [3:0] expDistinct = '0;
  logic [7:0] forbidMask = '0;
  logic [1:0] pairSel = '0;
  logic [3:0] ascCount, descCount, chgCount, forbidCount;
  logic       done, pass;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  mono_resp_check #(.OUT_BITS(3)) uut (
    .clk(clk), .rstN(rstN), .start(start), .wordValid(wordValid),
    .wordIn(wordIn), .seqEnd(seqEnd), .expDistinct(expDistinct),
    .forbidMask(forbidMask), .pairSel(pairSel), .ascCount(ascCount),
    .descCount(descCount), .chgCount(chgCount), .forbidCount(forbidCount),
    .done(done), .pass(pass)
  );

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic startRun(input logic [7:0] m, input logic [3:0] d, input logic [1:0] s);
    @(negedge clk);
    forbidMask = m; expDistinct = d; pairSel = s;
    start = 1'b1; wordValid = 1'b0; seqEnd = 1'b0;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic feed(input logic [2:0] w, input logic last);
    wordIn = w; wordValid = 1'b1; seqEnd = last;
    @(negedge clk);
    wordValid = 1'b0; seqEnd = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1 reset asc", ascCount, 0);
    check("R1 reset forb", forbidCount, 0);
    check("R1 reset done", done, 0);
    check("R1 reset pass", pass, 0);

    // table walk: R2 R4 R6 R7
    for (int v = 0; v < 8; v++) begin
      startRun(VEC[v].mask, VEC[v].expD, VEC[v].sel);
      for (int i = 0; i < int'(VEC[v].len); i++)
        feed(VEC[v].seq[23-3*i -: 3], i == int'(VEC[v].len) - 1);
      check($sformatf("R2 vec%0d asc", v), ascCount, VEC[v].eAsc);
      check($sformatf("R2 vec%0d desc", v), descCount, VEC[v].eDesc);
      check($sformatf("R2 vec%0d chg", v), chgCount, VEC[v].eChg);
      check($sformatf("R4 vec%0d forb", v), forbidCount, VEC[v].eForb);
      check($sformatf("R6 vec%0d done", v), done, 1);
      check($sformatf("R7 vec%0d pass", v), pass, VEC[v].ePass);
    end

    // R8: words after done are ignored
    feed(3'd3, 1'b0);
    feed(3'd0, 1'b1);
    check("R8 idle asc", ascCount, 0);
    check("R8 idle desc", descCount, 7);
    check("R8 idle chg", chgCount, 7);
    check("R8 idle done", done, 1);

    // R3: first word counted as forbidden but not as a step
    startRun(8'h08, 4'd1, 2'd1);
    feed(3'd3, 1'b1);
    check("R3 first chg", chgCount, 0);
    check("R3 first forb", forbidCount, 1);
    check("R3 first pass", pass, 0);

    // R2/R6: counts visible mid-run, done low while running
    startRun(8'h00, 4'd8, 2'd0);
    feed(3'd2, 1'b0);
    feed(3'd5, 1'b0);
    check("R2 mid asc", ascCount, 1);
    check("R6 mid done", done, 0);
    feed(3'd1, 1'b1);
    check("R2 mid desc", descCount, 1);
    check("R9 mid chg", chgCount, 2);

    // R10: restart mid-run forgets previous value
    startRun(8'h00, 4'd8, 2'd0);
    feed(3'd0, 1'b0);
    feed(3'd5, 1'b0);
    startRun(8'h00, 4'd8, 2'd0);
    check("R10 cleared chg", chgCount, 0);
    check("R10 cleared done", done, 0);
    feed(3'd1, 1'b0);
    feed(3'd2, 1'b1);
    check("R10 asc", ascCount, 1);
    check("R10 chg", chgCount, 1);
    check("R10 desc", descCount, 0);

    // R5: saturation under long alternating run
    startRun(8'h01, 4'd8, 2'd3);
    for (int i = 0; i < 40; i++)
      feed((i % 2 == 1) ? 3'd7 : 3'd0, i == 39);
    check("R5 sat asc", ascCount, 15);
    check("R5 sat desc", descCount, 15);
    check("R5 sat chg", chgCount, 15);
    check("R5 sat forb", forbidCount, 15);
    check("R5 sat pass", pass, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule